// File: doc/BRIEF.md
# Triangle-Wave PWM Counter with Peak Buffer Transfer

This block is the counting core of a center-aligned PWM timer. A counter climbs from zero toward a programmable peak value m. It goes one step past the peak to m+1, then turns and falls back to zero, where it turns upward again. The result is a symmetric triangle from 0 to m+1. The step from m to m+1 on the way up is the peak event. That event sets a sticky match flag. When the transfer mode is set to peak transfer, the same event also loads a bank of working compare registers from their buffer registers in a single edge.

Software prepares the next period's compare values in the buffers while the current period runs. The new values then take effect together at the top of the triangle, so a period never runs with a half-updated set. Everything is programmed through one write port. The flag is cleared by a separate clear input. The counter advances only on cycles with the enable high.

Top module: `tpwm_top`

## Requirements
- R1: With peak m (write address 0), an enabled counter rising past m produces the values m-1, m, m+1, m, m-1 on consecutive enabled cycles. It turns downward one step above the peak.
- R2: The match flag goes to 1 on the same edge that moves the count from m to m+1 while counting up.
- R3: When the 2-bit mode register (address 1, bits [1:0] of the data) holds 2'b11, the peak event copies buffer k (address 2+k) into working compare k (address 2+NBUF+k, output slice k of cmp_flat) for every k, on the same edge.
- R4: While the counter descends from m+1 to 0, the flag is never set and no buffer-to-working transfer occurs.
- R5: Once set, the flag stays 1 until a cycle with flag_clr high and no peak event, after which it reads 0.
- R6: The peak event never changes the peak value. After a transfer, the next turnaround still happens at the programmed m+1.
- R7: With any mode other than 2'b11, the peak event leaves the working compare registers unchanged. Those registers then change only through direct writes.
- R8: After reset the count is 0 and counting upward, the flag is 0, and the peak, mode, buffer and working registers are all 0.
- R9: Counting down, the counter turns upward on reaching 0, so the next value is 1. With m = 0 the count alternates 0, 1, and each 0-to-1 step is a peak event.
- R10: If flag_clr is high in the cycle of a peak event, the flag reads 1 afterwards.
- R11: If a direct write to working register k falls in the cycle of a transfer, the buffer value wins.
- R12: While en is low the count holds, the flag is not set and no transfer occurs, even when the count equals the peak.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable; the counter steps once per cycle while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: 0 peak, 1 mode, 2..NBUF+1 buffers, NBUF+2..2*NBUF+1 working compares |
| wr_data | input | W | Write data; the peak must be written below all-ones |
| flag_clr | input | 1 | Software clear of the match flag |
| count | output | W | Current counter value |
| cmp_flat | output | NBUF*W | Working compare registers, register k in bits [k*W +: W] |
| flag | output | 1 | Sticky peak-match flag |

## Verification
The hardest conditions to reach are the collisions at the peak event: a flag clear, or a direct write to a working register, landing in exactly the cycle that steps the count from m to m+1. The bench keeps its own model of the count and direction. It steps the block one enabled cycle at a time until the model shows the count equal to the peak on the way up, then issues the colliding clear or write in that cycle. The same tracking is used to park the counter at the peak with the enable low, and to run a peak of zero, where the event happens at the trough turnaround.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } dir_e;

   localparam logic [1:0] XFER_AT_PEAK = 2'b11;
   localparam int         MODE_W       = 2;

   localparam int ADDR_PEAK = 0;
   localparam int ADDR_MODE = 1;
   localparam int ADDR_BUF0 = 2;

   function automatic int work_base(input int nbuf);
      return ADDR_BUF0 + nbuf;
   endfunction

   function automatic int addr_span(input int nbuf);
      return ADDR_BUF0 + 2 * nbuf;
   endfunction

endpackage

// File: rtl/tpwm_updown_ctr.sv
module tpwm_updown_ctr
   import tpwm_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] peak,
   output logic [W-1:0] count,
   output logic         dir_up,
   output logic         peak_step
);

   localparam logic [W:0] ONE_EXT = (W+1)'(1);

   dir_e       dir_q;
   logic [W:0] turn_at;
   logic       go_up;

   always_comb begin
      turn_at = {1'b0, peak} + ONE_EXT;
      if (dir_q == DIR_UP) begin
         go_up = ({1'b0, count} < turn_at);
      end else begin
         go_up = (count == '0);
      end
   end

   assign peak_step = en && go_up && (count == peak);
   assign dir_up    = (dir_q == DIR_UP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         dir_q <= DIR_UP;
      end else if (en) begin
         if (go_up) begin
            count <= count + 1'b1;
            dir_q <= DIR_UP;
         end else begin
            count <= count - 1'b1;
            dir_q <= DIR_DOWN;
         end
      end
   end

endmodule

// File: rtl/tpwm_cmp_bank.sv
module tpwm_cmp_bank
   import tpwm_pkg::*;
#(
   parameter int W    = 16,
   parameter int NBUF = 3,
   parameter int AW   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              xfer_ev,
   output logic [W-1:0]      peak_q,
   output logic [MODE_W-1:0] mode_q,
   output logic [NBUF*W-1:0] cmp_flat
);

   localparam int            WBASE  = work_base(NBUF);
   localparam logic [AW-1:0] A_PEAK = AW'(ADDR_PEAK);
   localparam logic [AW-1:0] A_MODE = AW'(ADDR_MODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_q <= '0;
         mode_q <= '0;
      end else if (wr_en) begin
         if (wr_addr == A_PEAK) peak_q <= wr_data;
         if (wr_addr == A_MODE) mode_q <= wr_data[MODE_W-1:0];
      end
   end

   logic do_xfer;
   assign do_xfer = xfer_ev && (mode_q == XFER_AT_PEAK);

   for (genvar k = 0; k < NBUF; k++) begin : g_chan
      localparam logic [AW-1:0] A_BUF  = AW'(ADDR_BUF0 + k);
      localparam logic [AW-1:0] A_WORK = AW'(WBASE + k);

      logic [W-1:0] buf_q;
      logic [W-1:0] work_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            buf_q <= '0;
         end else if (wr_en && wr_addr == A_BUF) begin
            buf_q <= wr_data;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            work_q <= '0;
         end else if (do_xfer) begin
            work_q <= buf_q;
         end else if (wr_en && wr_addr == A_WORK) begin
            work_q <= wr_data;
         end
      end

      assign cmp_flat[k*W +: W] = work_q;
   end

endmodule

// File: rtl/tpwm_flag.sv
module tpwm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ev,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (set_ev) begin
         flag <= 1'b1;
      end else if (clr) begin
         flag <= 1'b0;
      end
   end

endmodule

// File: rtl/tpwm_top.sv
module tpwm_top
   import tpwm_pkg::*;
#(
   parameter int W    = 16,
   parameter int NBUF = 3,
   parameter int AW   = $clog2(addr_span(NBUF))
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              flag_clr,
   output logic [W-1:0]      count,
   output logic [NBUF*W-1:0] cmp_flat,
   output logic              flag
);

   if (W < 2 || W > 32) begin : g_bad_w
      $error("tpwm_top: W must lie in 2..32");
   end
   if (NBUF < 1 || NBUF > 8) begin : g_bad_nbuf
      $error("tpwm_top: NBUF must lie in 1..8");
   end
   if ((1 << AW) < addr_span(NBUF)) begin : g_bad_aw
      $error("tpwm_top: AW too narrow for the register map");
   end
   if (W < MODE_W) begin : g_bad_mode
      $error("tpwm_top: data too narrow for the mode field");
   end

   logic [W-1:0]      peak_q;
   logic [MODE_W-1:0] mode_q;
   logic              dir_up;
   logic              peak_step;

   tpwm_updown_ctr #(.W(W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .peak      (peak_q),
      .count     (count),
      .dir_up    (dir_up),
      .peak_step (peak_step)
   );

   tpwm_cmp_bank #(.W(W), .NBUF(NBUF), .AW(AW)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .xfer_ev  (peak_step),
      .peak_q   (peak_q),
      .mode_q   (mode_q),
      .cmp_flat (cmp_flat)
   );

   tpwm_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (peak_step),
      .clr    (flag_clr),
      .flag   (flag)
   );

endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
   parameter int W    = 16,
   parameter int NBUF = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic              wr_en,
   input logic              flag_clr,
   input logic [W-1:0]      count,
   input logic [NBUF*W-1:0] cmp_flat,
   input logic              flag,
   input logic [W-1:0]      peak_q,
   input logic [1:0]        mode_q,
   input logic              dir_up
);

   a_r1_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (count == W'($past(count) + 1'b1)) || (count == W'($past(count) - 1'b1)));

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(count) && !$rose(flag));

   a_r2_flag_at_peak: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> ($past(count) == $past(peak_q)) && (count == W'($past(count) + 1'b1)));

   a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag);

   a_r4_descent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!dir_up && count != '0 && !wr_en) |=> $stable(cmp_flat) && !$rose(flag));

   a_r7_no_xfer_other_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 2'b11 && !wr_en) |=> $stable(cmp_flat));

   a_r6_peak_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(peak_q));

   a_r9_trough_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count == '0) |=> (count == W'(1)));

endmodule

bind tpwm_top tpwm_checker #(.W(W), .NBUF(NBUF)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .wr_en    (wr_en),
   .flag_clr (flag_clr),
   .count    (count),
   .cmp_flat (cmp_flat),
   .flag     (flag),
   .peak_q   (peak_q),
   .mode_q   (mode_q),
   .dir_up   (dir_up)
);

// File: tb/tb_tpwm_top.sv
module tb_tpwm_top;

   localparam int W    = 16;
   localparam int NBUF = 3;
   localparam int AW   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              en = 1'b0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [W-1:0]      wr_data = '0;
   logic              flag_clr = 1'b0;
   logic [W-1:0]      count;
   logic [NBUF*W-1:0] cmp_flat;
   logic              flag;

   int checks = 0;
   int errors = 0;
   int cyc_n  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) cyc_n++;

   tpwm_top #(.W(W), .NBUF(NBUF), .AW(AW)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .flag_clr (flag_clr),
      .count    (count),
      .cmp_flat (cmp_flat),
      .flag     (flag)
   );

   typedef struct {
      int           cyc;
      logic [W-1:0] cnt;
      logic         flg;
      logic [NBUF*W-1:0] cmp;
      string        tag;
   } exp_t;

   exp_t exp_q[$];

   logic [W-1:0] m_cnt  = '0;
   logic         m_up   = 1'b1;
   logic         m_flag = 1'b0;
   logic [W-1:0] m_peak = '0;
   logic [1:0]   m_mode = '0;
   logic [W-1:0] m_buf [NBUF];
   logic [W-1:0] m_cmp [NBUF];

   function automatic logic m_rising();
      if (m_up) return ({1'b0, m_cnt} < ({1'b0, m_peak} + 17'd1));
      return (m_cnt == '0);
   endfunction

   task automatic drive(input logic e, input logic w, input logic [AW-1:0] a,
                        input logic [W-1:0] d, input logic c, input string tag);
      exp_t it;
      logic rise;
      logic ev;
      @(posedge clk);
      #1;
      en = e; wr_en = w; wr_addr = a; wr_data = d; flag_clr = c;
      rise = m_rising();
      ev   = e && rise && (m_cnt == m_peak);
      for (int k = 0; k < NBUF; k++) begin
         if (ev && m_mode == 2'b11) m_cmp[k] = m_buf[k];
         else if (w && int'(a) == 2 + NBUF + k) m_cmp[k] = d;
      end
      if (ev) m_flag = 1'b1;
      else if (c) m_flag = 1'b0;
      if (e) begin
         if (rise) begin m_cnt = m_cnt + 1'b1; m_up = 1'b1; end
         else begin m_cnt = m_cnt - 1'b1; m_up = 1'b0; end
      end
      if (w) begin
         if (a == 0) m_peak = d;
         else if (a == 1) m_mode = d[1:0];
         else if (int'(a) < 2 + NBUF) m_buf[int'(a) - 2] = d;
      end
      it.cyc = cyc_n + 1;
      it.cnt = m_cnt;
      it.flg = m_flag;
      for (int k = 0; k < NBUF; k++) it.cmp[k*W +: W] = m_cmp[k];
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) drive(1'b1, 1'b0, '0, '0, 1'b0, tag);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d, input string tag);
      drive(1'b0, 1'b1, a, d, 1'b0, tag);
   endtask

   task automatic run_to_peak(input string tag);
      for (int i = 0; i < 200; i++) begin
         if (m_cnt == m_peak && m_rising()) break;
         run(1, tag);
      end
   endtask

   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].cyc == cyc_n) begin
         exp_t it;
         it = exp_q.pop_front();
         checks++;
         if (count !== it.cnt || flag !== it.flg || cmp_flat !== it.cmp) begin
            errors++;
            $display("FAIL %s cyc %0d: count %0d flag %0b cmp %h, expected count %0d flag %0b cmp %h",
                     it.tag, cyc_n, count, flag, cmp_flat, it.cnt, it.flg, it.cmp);
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      finish_run();
   end

   initial begin
      for (int k = 0; k < NBUF; k++) begin m_buf[k] = '0; m_cmp[k] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      checks++;
      if (count !== '0 || flag !== 1'b0 || cmp_flat !== '0) begin
         errors++;
         $display("FAIL R8 reset: count %0d flag %0b cmp %h, expected 0 0 0", count, flag, cmp_flat);
      end
      @(posedge clk); #1 rst_n = 1'b1;

      // R8: registers idle at reset values, counter rises from 0
      run(3, "R8");

      // R1 R2 R3 R9: peak 5, transfer mode, buffers loaded
      wr(3'd0, 16'd5, "R1");
      wr(3'd2, 16'hA001, "R3");
      wr(3'd3, 16'hB002, "R3");
      wr(3'd4, 16'hC003, "R3");
      wr(3'd1, 16'h0003, "R3");
      run(20, "R1");

      // R5: flag stays set, then clears on request
      run(3, "R5");
      drive(1'b0, 1'b0, '0, '0, 1'b1, "R5");
      run(2, "R5");

      // R4: new buffers during descent are not transferred until the peak
      run_to_peak("R4");
      run(1, "R2");
      drive(1'b0, 1'b0, '0, '0, 1'b1, "R4");
      wr(3'd2, 16'h1111, "R4");
      run(6, "R4");

      // R6: peak kept after transfer, next turnaround still at m+1
      run(14, "R6");

      // R7: other modes never transfer; working registers written directly
      wr(3'd1, 16'h0001, "R7");
      wr(3'd5, 16'h0055, "R7");
      wr(3'd6, 16'h0066, "R7");
      wr(3'd3, 16'h2222, "R7");
      run(24, "R7");
      wr(3'd1, 16'h0002, "R7");
      run(14, "R7");

      // R12: enable low parked at the peak, no flag and no transfer
      wr(3'd1, 16'h0003, "R12");
      drive(1'b0, 1'b0, '0, '0, 1'b1, "R12");
      run_to_peak("R12");
      for (int i = 0; i < 5; i++) drive(1'b0, 1'b0, '0, '0, 1'b0, "R12");
      run(1, "R12");

      // R10: clear and set in the same cycle, set wins
      drive(1'b0, 1'b0, '0, '0, 1'b1, "R10");
      run_to_peak("R10");
      drive(1'b1, 1'b0, '0, '0, 1'b1, "R10");
      run(2, "R10");

      // R11: direct working write colliding with transfer
      wr(3'd4, 16'h7777, "R11");
      run_to_peak("R11");
      drive(1'b1, 1'b1, 3'd7, 16'h1234, 1'b0, "R11");
      run(2, "R11");

      // R9: peak 0 alternates 0/1, event at each 0-to-1 step
      wr(3'd0, 16'd0, "R9");
      run(20, "R9");
      drive(1'b0, 1'b0, '0, '0, 1'b1, "R9");
      run(4, "R9");

      repeat (4) @(posedge clk);
      @(negedge clk);
      #1;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
      end
      finish_run();
   end

endmodule